// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes an idle-high asynchronous serial line and turns each received character into a parallel byte held in a receive buffer. A strobe supplied from outside arrives sixteen times per bit period. The receiver finds a falling edge on the line and confirms the start bit at its midpoint. It then samples every following bit once, at the centre of that bit's sixteen-tick window. Characters carry 7 or 8 data bits, least significant bit first. An optional parity bit follows, set for even or odd sense, and then a stop bit.

When a character completes, it is copied into the buffer and a ready flag rises. Parity and framing errors are recorded with that character. An overrun flag records that an earlier character was lost. A read strobe clears the ready flag and the error flags. The receive enable only blocks new start edges, so a character that is already arriving is finished and buffered. A soft reset returns the receiver to idle and clears the flags and the interrupt enable. The interrupt request is the ready flag gated by that enable.

Top module: `uart_rx_core`

## Requirements
- R1: Data bits are assembled least significant bit first. With `cfg_eight`=1 all 8 bits appear on `rd_data`. With `cfg_eight`=0, 7 bits appear on `rd_data[6:0]` and `rd_data[7]` reads 0.
- R2: A low pulse shorter than half a bit period does not start a character, and `rx_ready` stays 0.
- R3: While `rx_en` is 0 and no character is in progress, a full frame on the line is not received and `rx_ready` stays 0.
- R4: If `rx_en` drops after the start bit of a character, that character is still completed and buffered.
- R5: `rx_ready` rises each time a completed character is loaded into the buffer.
- R6: A one-cycle `rd_strobe` clears `rx_ready`, `err_parity`, `err_frame` and `err_overrun`.
- R7: With `cfg_par_en`=1, the bit after the data is a parity bit. For even sense (`cfg_par_odd`=0) the data ones plus that bit total an even count; for odd sense they total an odd count. `err_parity` rises on a mismatch and is never set when `cfg_par_en`=0.
- R8: `err_frame` rises when the stop bit samples low, and the character is still buffered.
- R9: If a character completes while `rx_ready` is still 1, `err_overrun` rises and the new character replaces the buffer contents.
- R10: `rx_irq` equals `rx_ready` AND the interrupt enable. The enable is loaded from `irq_en_din` on `irq_en_wr`. While `soft_rst` is 1, `rx_ready`, the error flags and the interrupt enable are cleared.
- R11: After `rst`, `rx_ready`, `rx_irq` and all error flags are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset: idles the receiver, clears flags and interrupt enable |
| rx_en | input | 1 | Receive enable, gates acceptance of new start edges |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Buffer read, clears ready and error flags |
| irq_en_wr | input | 1 | Load strobe for the interrupt enable |
| irq_en_din | input | 1 | Value loaded into the interrupt enable |
| rd_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Parity mismatch on the buffered character |
| err_frame | output | 1 | Stop bit sampled low on the buffered character |
| err_overrun | output | 1 | A character arrived before the previous one was read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench aims at the edges of the enable behaviour. One test drops the enable in the middle of a character, so a design that aborts on the spot loses the byte. Another sends a full frame while disabled, so a design that ignores the enable accepts it. A short low glitch shows whether the start bit is really confirmed at its midpoint, or whether any falling edge launches a bogus character. The 7-bit frames show whether the data ends up misaligned by one position, and frames with flipped parity, a low stop bit and two back-to-back unread characters cover the three error flags. A final soft-reset sequence catches a design that keeps the interrupt enable, because the next ready flag would then still raise an interrupt.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_result_t;

    // Parity bit a transmitter would append for the given data and sense.
    function automatic logic par_expect(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       srst,
    input  logic       en,
    input  logic       tick,
    input  logic       line,
    input  rx_cfg_t    cfg,
    output logic       done,
    output rx_result_t result
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       idx_q;
    logic [7:0]       shreg_q;
    logic             par_bit_q;
    logic             prev_q;
    logic [7:0]       aligned;
    logic [2:0]       last_idx;

    assign aligned  = cfg.eight ? shreg_q : {1'b0, shreg_q[7:1]};
    assign last_idx = cfg.eight ? 3'd7 : 3'd6;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_bit_q <= 1'b0;
            prev_q    <= 1'b1;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev_q <= line;
                unique case (state_q)
                    RX_IDLE: begin
                        if (en && prev_q && !line) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shreg_q <= {line, shreg_q[7:1]};
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == last_idx)
                                state_q <= cfg.par_en ? RX_PAR : RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            par_bit_q <= line;
                            state_q   <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q          <= '0;
                            done           <= 1'b1;
                            result.data    <= aligned;
                            result.par_err <= cfg.par_en &&
                                              (par_bit_q != par_expect(aligned, cfg.par_odd));
                            result.frm_err <= !line;
                            state_q        <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R3: a disabled, idle receiver never leaves idle
    a_r3_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && !en) |=> state_q == RX_IDLE);

    // R2: a start bit that reads high at its midpoint is abandoned
    a_r2_false_start: assert property (@(posedge clk) disable iff (rst || srst)
        (state_q == RX_START && tick && cnt_q == MID && line) |=> state_q == RX_IDLE);

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       srst,
    input  logic       done,
    input  rx_result_t result,
    input  logic       rd,
    input  logic       ie_wr,
    input  logic       ie_din,
    output logic [7:0] data,
    output logic       rdy,
    output logic       perr,
    output logic       ferr,
    output logic       ovr,
    output logic       ie
);
    always_ff @(posedge clk) begin
        if (rst) data <= '0;
        else if (done && !srst) data <= result.data;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            rdy  <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            ovr  <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (ie_wr) ie <= ie_din;
            if (done) begin
                rdy  <= 1'b1;
                perr <= result.par_err;
                ferr <= result.frm_err;
                ovr  <= ovr | (rdy & !rd);
            end else if (rd) begin
                rdy  <= 1'b0;
                perr <= 1'b0;
                ferr <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    a_r5_ready_on_load: assert property (@(posedge clk) disable iff (rst || srst)
        done |=> rdy);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst || srst)
        (rd && !done) |=> (!rdy && !perr && !ferr && !ovr));

    a_r10_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!rdy && !ie));

    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst || srst)
        (done && rdy && !rd) |=> ovr);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       rx_en,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       cfg_eight,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_strobe,
    input  logic       irq_en_wr,
    input  logic       irq_en_din,
    output logic [7:0] rd_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       rx_irq
);
    logic       line_s;
    logic       done;
    logic       ie;
    rx_cfg_t    cfg;
    rx_result_t result;

    assign cfg = '{eight: cfg_eight, par_en: cfg_par_en, par_odd: cfg_par_odd};

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
    );

    rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk(clk), .rst(rst), .srst(soft_rst), .en(rx_en && !soft_rst),
        .tick(tick16), .line(line_s), .cfg(cfg), .done(done), .result(result)
    );

    rx_buffer u_buf (
        .clk(clk), .rst(rst), .srst(soft_rst), .done(done), .result(result),
        .rd(rd_strobe), .ie_wr(irq_en_wr), .ie_din(irq_en_din),
        .data(rd_data), .rdy(rx_ready), .perr(err_parity), .ferr(err_frame),
        .ovr(err_overrun), .ie(ie)
    );

    assign rx_irq = rx_ready & ie;

    // R10: the interrupt never fires without a ready character
    a_r10_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_ready);
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1, soft_rst = 1'b0, rx_en = 1'b0, tick16 = 1'b0, rxd = 1'b1;
    logic cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic rd_strobe = 1'b0, irq_en_wr = 1'b0, irq_en_din = 1'b0;
    logic [7:0] rd_data;
    logic rx_ready, err_parity, err_frame, err_overrun, rx_irq;
    int   n_checks = 0, n_fails = 0;
    int   tick_cnt = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick16   <= (tick_cnt == TICK_DIV - 1);
    end

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_en(rx_en), .tick16(tick16),
        .rxd(rxd), .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .rd_strobe(rd_strobe), .irq_en_wr(irq_en_wr),
        .irq_en_din(irq_en_din), .rd_data(rd_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        wait_clks(BIT_CLKS);
    endtask

    // drop_at: data-bit index at which rx_en is cleared (-1 = never)
    task automatic send_frame(input logic [7:0] d, input logic eight, input logic pen,
                              input logic podd, input logic flip_par,
                              input logic bad_stop, input int drop_at);
        int   nb;
        logic p;
        nb = eight ? 8 : 7;
        cfg_eight = eight; cfg_par_en = pen; cfg_par_odd = podd;
        p = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == drop_at) rx_en = 1'b0;
            p = p ^ d[i];
            drive_bit(d[i]);
        end
        if (pen) drive_bit(p ^ podd ^ flip_par);
        drive_bit(!bad_stop);
        rxd = 1'b1;
        wait_clks(BIT_CLKS);
    endtask

    task automatic read_buf();
        rd_strobe = 1'b1;
        wait_clks(1);
        rd_strobe = 1'b0;
        wait_clks(2);
    endtask

    task automatic t_reset();
        check("R11 ready", rx_ready, 0);
        check("R11 irq", rx_irq, 0);
        check("R11 errors", {err_parity, err_frame, err_overrun}, 0);
        check("R11 data", rd_data, 0);
    endtask

    task automatic t_eight_bit();
        send_frame(8'hA5, 1, 0, 0, 0, 0, -1);
        check("R5 ready after frame", rx_ready, 1);
        check("R1 8-bit data", rd_data, 8'hA5);
        check("R7 no parity error when disabled", err_parity, 0);
        read_buf();
        check("R6 read clears ready", rx_ready, 0);
        send_frame(8'h3C, 1, 0, 0, 0, 0, -1);
        check("R1 8-bit data second", rd_data, 8'h3C);
        read_buf();
    endtask

    task automatic t_seven_bit();
        send_frame(8'h5B, 0, 0, 0, 0, 0, -1);
        check("R1 7-bit data", rd_data, 8'h5B);
        read_buf();
        send_frame(8'h7F, 0, 1, 1, 0, 0, -1);
        check("R1 7-bit odd parity data", rd_data, 8'h7F);
        check("R7 7-bit odd parity ok", err_parity, 0);
        read_buf();
    endtask

    task automatic t_parity();
        send_frame(8'h96, 1, 1, 0, 0, 0, -1);
        check("R7 even parity ok", err_parity, 0);
        read_buf();
        send_frame(8'h96, 1, 1, 0, 1, 0, -1);
        check("R7 even parity mismatch", err_parity, 1);
        check("R7 data kept", rd_data, 8'h96);
        read_buf();
        check("R6 read clears parity error", err_parity, 0);
        send_frame(8'h01, 1, 1, 1, 1, 0, -1);
        check("R7 odd parity mismatch", err_parity, 1);
        read_buf();
    endtask

    task automatic t_framing();
        send_frame(8'h42, 1, 0, 0, 0, 1, -1);
        check("R8 frame error", err_frame, 1);
        check("R8 char buffered", rd_data, 8'h42);
        read_buf();
        check("R6 read clears frame error", err_frame, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        wait_clks(BIT_CLKS / 4);
        rxd = 1'b1;
        wait_clks(3 * BIT_CLKS);
        check("R2 glitch ignored", rx_ready, 0);
    endtask

    task automatic t_enable();
        rx_en = 1'b0;
        wait_clks(4);
        send_frame(8'h11, 1, 0, 0, 0, 0, -1);
        check("R3 disabled idle receives nothing", rx_ready, 0);
        rx_en = 1'b1;
        wait_clks(4);
        send_frame(8'hC3, 1, 0, 0, 0, 0, 3);
        check("R4 character finished after disable", rx_ready, 1);
        check("R4 data", rd_data, 8'hC3);
        read_buf();
        send_frame(8'h22, 1, 0, 0, 0, 0, -1);
        check("R3 stays off after completion", rx_ready, 0);
        rx_en = 1'b1;
        wait_clks(4);
    endtask

    task automatic t_overrun();
        send_frame(8'h10, 1, 0, 0, 0, 0, -1);
        check("R9 no overrun first", err_overrun, 0);
        send_frame(8'h20, 1, 0, 0, 0, 0, -1);
        check("R9 overrun set", err_overrun, 1);
        check("R9 buffer overwritten", rd_data, 8'h20);
        read_buf();
        check("R6 read clears overrun", err_overrun, 0);
    endtask

    task automatic t_soft_reset();
        irq_en_din = 1'b1; irq_en_wr = 1'b1;
        wait_clks(1);
        irq_en_wr = 1'b0;
        send_frame(8'h77, 1, 0, 0, 0, 0, -1);
        check("R10 irq with enable", rx_irq, 1);
        soft_rst = 1'b1;
        wait_clks(2);
        soft_rst = 1'b0;
        wait_clks(1);
        check("R10 soft reset clears ready", rx_ready, 0);
        check("R10 soft reset clears irq", rx_irq, 0);
        send_frame(8'h88, 1, 0, 0, 0, 0, -1);
        check("R10 ready after soft reset", rx_ready, 1);
        check("R10 enable was cleared", rx_irq, 0);
        read_buf();
    endtask

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        t_reset();
        rx_en = 1'b1;
        wait_clks(BIT_CLKS);
        t_eight_bit();
        t_seven_bit();
        t_parity();
        t_framing();
        t_glitch();
        t_enable();
        t_overrun();
        t_soft_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule